// File: doc/BRIEF.md
# Multiprocessor-Mode UART Receiver

This block receives asynchronous serial frames on a single input line and hands each byte to software through a small register interface. A frame is one low start bit, then `DATA_W` data bits with the least significant bit first, then one address-marker bit, then one stop bit. The line is examined on a sample-enable input that pulses `OSR` times per bit. Three samples around the middle of each bit are combined by majority vote, and the start bit must pass the same vote.

Software enables the receiver through a control register. For multi-drop links it can also arm an ID filter. While the filter is armed, frames whose marker bit is 0 are thrown away. The first frame whose marker bit is 1 is delivered, and delivering it disarms the filter. A status register carries a data-ready flag, an overrun flag, a framing-error flag and the present line level, which lets software recognise a held-low break. While either error flag is set, the receiver accepts no frame.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset the status register (address 1) reads 0x08 with the line idle high. The control register (address 0) reads 0x00. Status bit 0 is data-ready, bit 1 is overrun, bit 2 is framing error and bit 3 is the line level. Control bit 0 is receive enable and bit 1 is the ID filter.
- R2: With receive enable set, the filter clear and no flag set, a complete frame loads its data bits into the data register (address 2), with the first data bit received as bit 0, and sets data-ready. The marker bit does not matter in this case.
- R3: While receive enable is 0, completed frames change neither the data register nor any flag.
- R4: While the ID filter is 1, a frame with marker bit 0 leaves the data register, every flag and the filter bit unchanged.
- R5: While the ID filter is 1, a frame with marker bit 1 that is loaded sets data-ready and clears the filter bit without any write from software.
- R6: A frame that completes while data-ready is 1 sets the overrun flag and leaves the data register unchanged.
- R7: A frame whose stop bit is sampled 0 sets the framing-error flag, and its data is still loaded with data-ready set.
- R8: While the overrun or framing-error flag is 1, no frame is accepted. Reception resumes once both flags are 0.
- R9: A status flag is cleared only by writing 0 to its bit after a status read has returned that bit as 1. Writing 1 has no effect, and so does writing 0 without that earlier read.
- R10: Status bit 3 follows the receive line after `SYNC_STAGES` clocks, so a held-low line reads as 0.
- R11: A low pulse shorter than half a bit time does not start a frame. A low level that lasts past the mid-bit samples starts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Oversampling strobe, `OSR` pulses per bit |
| rxd | input | 1 | Serial receive line, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 3 | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |

## Verification
A frame's effect on the flags and the data register appears four clocks after the third sample of the stop bit: two synchronizer stages, the registered completion strobe and then the flag registers. The bench holds every stop bit for a full bit time and then waits four more idle clocks before it reads anything. All register reads are combinational and are sampled one time unit after a falling edge. Tests of the line-level bit and of rejected glitches allow at least 40 clocks before they sample. After a break, the bench waits longer than one frame so that any partial frame still in progress has ended before the error flags are cleared.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
   // register select codes
   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;
   // write data width needed by control and status writes
   localparam int WR_W = 3;
   // control bit positions
   localparam int CT_EN  = 0;
   localparam int CT_IDF = 1;
   // status bit positions
   localparam int ST_FULL = 0;
   localparam int ST_OVR  = 1;
   localparam int ST_FE   = 2;
   localparam int ST_LINE = 3;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_START = 2'd1,
      S_BITS  = 2'd2
   } rx_state_e;
endpackage

// File: rtl/mpu_rx_sync.sv
module mpu_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '1;
      else        q <= {q[STAGES-2:0], din};
   end

   assign dout = q[STAGES-1];
endmodule

// File: rtl/mpu_rx_frame.sv
module mpu_rx_frame
   import mp_uart_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int OSR      = 16,
   parameter bit MAJORITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              rxd,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              mp,
   output logic              stop
);
   localparam int CW  = $clog2(OSR);
   localparam int BW  = $clog2(DATA_W + 2);
   localparam logic [CW-1:0] C_LAST = CW'(OSR - 1);
   localparam logic [CW-1:0] C_PRE  = CW'(OSR / 2 - 1);
   localparam logic [CW-1:0] C_MID  = CW'(OSR / 2);
   localparam logic [CW-1:0] C_DEC  = CW'(OSR / 2 + 1);
   localparam logic [BW-1:0] B_STOP = BW'(DATA_W + 1);

   rx_state_e     state;
   logic [CW-1:0] cnt;
   logic [BW-1:0] bidx;
   logic [DATA_W:0] shreg;
   logic          vote;

   generate
      if (MAJORITY) begin : g_vote3
         logic [1:0] smp;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) smp <= '1;
            else if (tick) begin
               if (cnt == C_PRE) smp[0] <= rxd;
               if (cnt == C_MID) smp[1] <= rxd;
            end
         end
         assign vote = (smp[0] & smp[1]) | (smp[0] & rxd) | (smp[1] & rxd);
      end else begin : g_vote1
         assign vote = rxd;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         cnt   <= '0;
         bidx  <= '0;
         shreg <= '0;
         done  <= 1'b0;
         data  <= '0;
         mp    <= 1'b0;
         stop  <= 1'b1;
      end else if (!en) begin
         state <= S_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            if (state == S_IDLE) begin
               if (!rxd) begin
                  state <= S_START;
                  cnt   <= CW'(1);
               end
            end else begin
               cnt <= (cnt == C_LAST) ? '0 : cnt + CW'(1);
               if (cnt == C_DEC) begin
                  if (state == S_START) begin
                     if (vote) state <= S_IDLE;
                     else begin
                        state <= S_BITS;
                        bidx  <= '0;
                     end
                  end else if (bidx == B_STOP) begin
                     done  <= 1'b1;
                     data  <= shreg[DATA_W-1:0];
                     mp    <= shreg[DATA_W];
                     stop  <= vote;
                     state <= S_IDLE;
                  end else begin
                     shreg <= {vote, shreg[DATA_W:1]};
                     bidx  <= bidx + BW'(1);
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/mpu_rx_regs.sv
module mpu_rx_regs
   import mp_uart_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [WR_W-1:0]   reg_wdata,
   input  logic              line,
   input  logic              fr_done,
   input  logic [DATA_W-1:0] fr_data,
   input  logic              fr_mp,
   input  logic              fr_stop,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              rx_en,
   output logic              id_filter,
   output logic              rx_full,
   output logic              rx_ovr,
   output logic              rx_fe,
   output logic [DATA_W-1:0] rx_data
);
   logic arm_full, arm_ovr, arm_fe;
   logic take, load, ovr_ev;
   logic st_rd, st_wr, ct_wr;
   logic clr_full, clr_ovr, clr_fe;

   assign take   = fr_done && rx_en && !rx_ovr && !rx_fe && !(id_filter && !fr_mp);
   assign load   = take && !rx_full;
   assign ovr_ev = take && rx_full;

   assign st_rd = reg_rd && (reg_addr == ADDR_STAT);
   assign st_wr = reg_wr && (reg_addr == ADDR_STAT);
   assign ct_wr = reg_wr && (reg_addr == ADDR_CTRL);

   assign clr_full = st_wr && arm_full && !reg_wdata[ST_FULL];
   assign clr_ovr  = st_wr && arm_ovr  && !reg_wdata[ST_OVR];
   assign clr_fe   = st_wr && arm_fe   && !reg_wdata[ST_FE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en     <= 1'b0;
         id_filter <= 1'b0;
         rx_full   <= 1'b0;
         rx_ovr    <= 1'b0;
         rx_fe     <= 1'b0;
         arm_full  <= 1'b0;
         arm_ovr   <= 1'b0;
         arm_fe    <= 1'b0;
         rx_data   <= '0;
      end else begin
         if (ct_wr) rx_en <= reg_wdata[CT_EN];

         if (ct_wr)     id_filter <= reg_wdata[CT_IDF];
         else if (load) id_filter <= 1'b0;

         if (load)          rx_full <= 1'b1;
         else if (clr_full) rx_full <= 1'b0;
         if (clr_full)                arm_full <= 1'b0;
         else if (st_rd && rx_full)   arm_full <= 1'b1;

         if (ovr_ev)       rx_ovr <= 1'b1;
         else if (clr_ovr) rx_ovr <= 1'b0;
         if (clr_ovr)               arm_ovr <= 1'b0;
         else if (st_rd && rx_ovr)  arm_ovr <= 1'b1;

         if (load && !fr_stop) rx_fe <= 1'b1;
         else if (clr_fe)      rx_fe <= 1'b0;
         if (clr_fe)               arm_fe <= 1'b0;
         else if (st_rd && rx_fe)  arm_fe <= 1'b1;

         if (load) rx_data <= fr_data;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_CTRL: begin
            reg_rdata[CT_EN]  = rx_en;
            reg_rdata[CT_IDF] = id_filter;
         end
         ADDR_STAT: begin
            reg_rdata[ST_FULL] = rx_full;
            reg_rdata[ST_OVR]  = rx_ovr;
            reg_rdata[ST_FE]   = rx_fe;
            reg_rdata[ST_LINE] = line;
         end
         ADDR_DATA: reg_rdata = rx_data;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
   import mp_uart_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit MAJORITY    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_en,
   input  logic              rxd,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [WR_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);
   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("OSR must be even and at least 4");
      end
      if (DATA_W < 4) begin : g_bad_width
         $error("DATA_W must be at least 4 to hold the status bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              rxd_s;
   logic              fr_done, fr_mp, fr_stop;
   logic [DATA_W-1:0] fr_data;
   logic              rx_en, id_filter, rx_full, rx_ovr, rx_fe;
   logic [DATA_W-1:0] rx_data;

   mpu_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
   );

   mpu_rx_frame #(.DATA_W(DATA_W), .OSR(OSR), .MAJORITY(MAJORITY)) u_frame (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(sample_en), .rxd(rxd_s),
      .done(fr_done), .data(fr_data), .mp(fr_mp), .stop(fr_stop)
   );

   mpu_rx_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .line(rxd_s),
      .fr_done(fr_done), .fr_data(fr_data), .fr_mp(fr_mp), .fr_stop(fr_stop),
      .reg_rdata(reg_rdata), .rx_en(rx_en), .id_filter(id_filter),
      .rx_full(rx_full), .rx_ovr(rx_ovr), .rx_fe(rx_fe), .rx_data(rx_data)
   );
endmodule

// File: rtl/mpu_rx_checker.sv
module mpu_rx_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              fr_done,
   input logic [DATA_W-1:0] fr_data,
   input logic              fr_mp,
   input logic              fr_stop,
   input logic              rx_en,
   input logic              id_filter,
   input logic              rx_full,
   input logic              rx_ovr,
   input logic              rx_fe,
   input logic [DATA_W-1:0] rx_data
);
   logic open_ok;
   assign open_ok = rx_en && !rx_ovr && !rx_fe && !reg_wr;

   assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !rx_full) |=> !rx_full);

   assert_filter_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (id_filter && fr_done && !fr_mp && !reg_wr) |=>
         ($stable(rx_data) && $stable(rx_full) && $stable(rx_ovr) && $stable(rx_fe) && id_filter));

   assert_id_delivers_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (id_filter && fr_done && fr_mp && !rx_full && open_ok) |=>
         (rx_full && !id_filter && rx_data == $past(fr_data)));

   assert_overrun_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_done && rx_full && open_ok && !(id_filter && !fr_mp)) |=>
         (rx_ovr && $stable(rx_data)));

   assert_framing_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_done && !fr_stop && !rx_full && open_ok && !(id_filter && !fr_mp)) |=>
         (rx_fe && rx_full));

   assert_error_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_ovr || rx_fe) && !rx_full) |=> !rx_full);

   assert_error_hold_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovr || rx_fe) |=> $stable(rx_data));
endmodule

bind mp_uart_rx mpu_rx_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
   .fr_done(fr_done), .fr_data(fr_data), .fr_mp(fr_mp), .fr_stop(fr_stop),
   .rx_en(rx_en), .id_filter(id_filter), .rx_full(rx_full),
   .rx_ovr(rx_ovr), .rx_fe(rx_fe), .rx_data(rx_data)
);

// File: tb/mp_uart_rx_tb.sv
module mp_uart_rx_tb;
   localparam int CLK_PERIOD = 10;
   localparam int OSR        = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_en = 1'b1;
   logic       rxd = 1'b1;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [2:0] reg_wdata = 3'd0;
   logic [7:0] reg_rdata;

   int  n_chk = 0;
   int  n_err = 0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mp_uart_rx #(.DATA_W(8), .OSR(OSR), .SYNC_STAGES(2), .MAJORITY(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd(rxd),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_rd = 1'b1;
      reg_addr = a;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [2:0] d);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_addr = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic bitout(input logic b);
      rxd = b;
      repeat (OSR) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input logic mpb, input logic stopb);
      @(negedge clk);
      bitout(1'b0);
      for (int i = 0; i < 8; i++) bitout(d[i]);
      bitout(mpb);
      bitout(stopb);
      rxd = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic expect_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset values
      expect_reg("R1", 2'd1, 8'h08);
      expect_reg("R1", 2'd0, 8'h00);

      // R3 receiver disabled
      send(8'hA5, 1'b1, 1'b1);
      expect_reg("R3", 2'd1, 8'h08);
      expect_reg("R3", 2'd2, 8'h00);

      // R2 sweep all data values, marker bit alternating
      wr(2'd0, 3'b001);
      for (int v = 0; v < 256; v++) begin
         send(8'(v), v[0], 1'b1);
         expect_reg("R2", 2'd1, 8'h09);
         expect_reg("R2", 2'd2, 8'(v));
         wr(2'd1, 3'b000);
      end
      expect_reg("R2", 2'd1, 8'h08);

      // R9 clear rules
      send(8'h3C, 1'b1, 1'b1);
      wr(2'd1, 3'b000);
      expect_reg("R9", 2'd1, 8'h09);
      wr(2'd1, 3'b111);
      expect_reg("R9", 2'd1, 8'h09);
      wr(2'd1, 3'b000);
      expect_reg("R9", 2'd1, 8'h08);

      // R6 overrun keeps old data
      send(8'h11, 1'b1, 1'b1);
      send(8'h22, 1'b1, 1'b1);
      expect_reg("R6", 2'd1, 8'h0B);
      expect_reg("R6", 2'd2, 8'h11);

      // R8 frozen while overrun set
      wr(2'd1, 3'b010);
      expect_reg("R8", 2'd1, 8'h0A);
      send(8'h33, 1'b1, 1'b1);
      expect_reg("R8", 2'd1, 8'h0A);
      expect_reg("R8", 2'd2, 8'h11);
      wr(2'd1, 3'b000);
      expect_reg("R8", 2'd1, 8'h08);
      send(8'h44, 1'b1, 1'b1);
      expect_reg("R8", 2'd1, 8'h09);
      expect_reg("R8", 2'd2, 8'h44);
      wr(2'd1, 3'b000);

      // R7 framing error loads data
      send(8'h5A, 1'b1, 1'b0);
      expect_reg("R7", 2'd1, 8'h0D);
      expect_reg("R7", 2'd2, 8'h5A);
      wr(2'd1, 3'b100);
      expect_reg("R8", 2'd1, 8'h0C);
      send(8'h66, 1'b1, 1'b1);
      expect_reg("R8", 2'd1, 8'h0C);
      expect_reg("R8", 2'd2, 8'h5A);

      // R10 break level visible
      @(negedge clk);
      rxd = 1'b0;
      repeat (40) @(negedge clk);
      expect_reg("R10", 2'd1, 8'h04);
      rxd = 1'b1;
      repeat (250) @(negedge clk);
      expect_reg("R10", 2'd1, 8'h0C);
      wr(2'd1, 3'b000);
      expect_reg("R8", 2'd1, 8'h08);

      // R4 / R5 ID filter
      wr(2'd0, 3'b011);
      expect_reg("R4", 2'd0, 8'h03);
      send(8'h77, 1'b0, 1'b1);
      expect_reg("R4", 2'd1, 8'h08);
      expect_reg("R4", 2'd0, 8'h03);
      expect_reg("R4", 2'd2, 8'h44 ^ 8'h44 ^ 8'h5A);
      send(8'h81, 1'b1, 1'b1);
      expect_reg("R5", 2'd1, 8'h09);
      expect_reg("R5", 2'd2, 8'h81);
      expect_reg("R5", 2'd0, 8'h01);
      wr(2'd1, 3'b000);
      send(8'h18, 1'b0, 1'b1);
      expect_reg("R2", 2'd1, 8'h09);
      expect_reg("R2", 2'd2, 8'h18);
      wr(2'd1, 3'b000);

      // R11 short low pulses rejected
      for (int len = 1; len < OSR / 2; len++) begin
         @(negedge clk);
         rxd = 1'b0;
         repeat (len) @(negedge clk);
         rxd = 1'b1;
         repeat (40) @(negedge clk);
         expect_reg("R11", 2'd1, 8'h08);
      end
      send(8'hC3, 1'b1, 1'b1);
      expect_reg("R11", 2'd1, 8'h09);
      expect_reg("R11", 2'd2, 8'hC3);
      wr(2'd1, 3'b000);

      // R11 a low level past mid-bit starts a frame of all ones
      @(negedge clk);
      rxd = 1'b0;
      repeat (OSR / 2 + 2) @(negedge clk);
      rxd = 1'b1;
      repeat (12 * OSR) @(negedge clk);
      expect_reg("R11", 2'd1, 8'h09);
      expect_reg("R11", 2'd2, 8'hFF);
      wr(2'd1, 3'b000);

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule